// File: doc/BRIEF.md
# Segment Row Latch with Display Modes

This block holds one row of segment data, read from the display memory, for the length of one common period. The line-clock strobe from the timing generator tells it when a fresh row is on its input; at most one row is taken per strobe pulse. Between captures the held row drives the segment outputs. Writes from the host processor into the display memory do not disturb the held row.

The row passes through a mode stage before it reaches the segment drivers. Three controls set the mode: a display enable, an all-pixels-lit force, and an inversion. The mode stage alters only what leaves the block. The held row and the memory image stay as they are, so clearing a mode brings back the original picture at once. Mode changes reach the outputs combinationally and do not wait for the next strobe.

A three-state strobe machine paces the captures:
- **BLANK** is the state after reset. The outputs are forced dark. The transition BLANK→ARMED happens when the strobe is sampled low.
- **ARMED** waits for a strobe. The transition ARMED→HELD happens when the strobe is sampled high, and the row is captured on that same edge.
- **HELD** ignores the strobe level until it drops. The transition HELD→ARMED happens when the strobe is sampled low.

A mode decoder turns the three controls, together with the BLANK state, into one of four output modes: BLANK, ALLON, INVERT or NORMAL. Replicated slice multiplexers then apply that mode to the held row.

Top module: `seg_line_latch`

## Requirements
- R1: From reset until the first rising clock edge at which `lp_strobe` is sampled low, `seg_out` is all zeros whatever the mode inputs are.
- R2: At a rising clock edge where `lp_strobe` is sampled 1, the machine is armed (the strobe was sampled 0 at an earlier edge since the last capture or since reset), and R1 no longer applies, `row_data` is captured. `seg_out` reflects the captured row from that edge onwards.
- R3: While `lp_strobe` stays high after a capture, further changes of `row_data` are not captured.
- R4: Changes of `row_data` while `lp_strobe` is low have no effect on `seg_out`.
- R5: `disp_on` = 0 forces every bit of `seg_out` to 0. This has the highest priority.
- R6: With `disp_on` = 1 and `all_on` = 1, every bit of `seg_out` is 1, regardless of `reverse_on` and of the held row.
- R7: With `disp_on` = 1 and `all_on` = 0, bit i of `seg_out` equals bit i of the held row when `reverse_on` = 0, and its complement when `reverse_on` = 1.
- R8: A change of any mode input appears on `seg_out` without a clock edge.
- R9: Mode changes never alter the held row. Returning to normal mode shows the last captured row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_strobe | input | 1 | Line-clock strobe; a high pulse requests one row capture |
| row_data | input | SEG_W (128) | Row read from display memory, bit i feeds segment i |
| disp_on | input | 1 | 1 = display enabled, 0 = all segments dark |
| all_on | input | 1 | 1 = all segments lit (when enabled) |
| reverse_on | input | 1 | 1 = inverted picture |
| seg_out | output | SEG_W (128) | Segment pattern to the drivers |

## Verification
The hardest situation to reach from the ports is a strobe that stays high across several edges while `row_data` keeps changing, because only the first edge may capture. A second hard case is a strobe that is already high when reset is released, which must not capture at all. Directed sequences hold the strobe high during reset, and hold it high for several cycles while driving fresh rows. Random stimulus from a fixed seed then mixes short and long strobe pulses with random mode combinations. Mode changes are also applied between clock edges, and `seg_out` is checked before the next edge.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

    typedef enum logic [1:0] {
        STB_BLANK = 2'd0,
        STB_ARMED = 2'd1,
        STB_HELD  = 2'd2
    } stb_state_e;

    typedef enum logic [1:0] {
        OUT_BLANK  = 2'd0,
        OUT_ALLON  = 2'd1,
        OUT_INVERT = 2'd2,
        OUT_NORMAL = 2'd3
    } out_mode_e;

endpackage

// File: rtl/seg_strobe_fsm.sv
module seg_strobe_fsm
    import seg_disp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    output logic       load_en,
    output logic       blank,
    output stb_state_e state_o
);

    stb_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_BLANK: if (!strobe) state_d = STB_ARMED;
            STB_ARMED: if (strobe)  state_d = STB_HELD;
            STB_HELD:  if (!strobe) state_d = STB_ARMED;
            default:                state_d = STB_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STB_BLANK;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_en = 1'b0;
        blank   = 1'b0;
        unique case (state_q)
            STB_BLANK: blank   = 1'b1;
            STB_ARMED: load_en = strobe;
            STB_HELD:  ;
            default:   blank   = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/seg_row_reg.sv
module seg_row_reg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= d;
    end

endmodule

// File: rtl/seg_mode_decode.sv
module seg_mode_decode
    import seg_disp_pkg::*;
(
    input  logic      blank,
    input  logic      disp_on,
    input  logic      all_on,
    input  logic      reverse_on,
    output out_mode_e mode
);

    // priority: dark, then all lit, then inverted, then normal
    always_comb begin
        if (blank || !disp_on) mode = OUT_BLANK;
        else if (all_on)       mode = OUT_ALLON;
        else if (reverse_on)   mode = OUT_INVERT;
        else                   mode = OUT_NORMAL;
    end

endmodule

// File: rtl/seg_slice_mux.sv
module seg_slice_mux
    import seg_disp_pkg::*;
#(
    parameter int W = 32
) (
    input  out_mode_e    mode,
    input  logic [W-1:0] row,
    output logic [W-1:0] seg
);

    always_comb begin
        unique case (mode)
            OUT_BLANK:  seg = '0;
            OUT_ALLON:  seg = '1;
            OUT_INVERT: seg = ~row;
            OUT_NORMAL: seg = row;
            default:    seg = '0;
        endcase
    end

endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch
    import seg_disp_pkg::*;
#(
    parameter int SEG_W   = 128,
    parameter int SLICE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_strobe,
    input  logic [SEG_W-1:0] row_data,
    input  logic             disp_on,
    input  logic             all_on,
    input  logic             reverse_on,
    output logic [SEG_W-1:0] seg_out
);

    localparam int NSLICE = SEG_W / SLICE_W;

    logic             load_en;
    logic             blank;
    stb_state_e       fsm_state;
    logic [SEG_W-1:0] row_q;
    out_mode_e        mode;

    seg_strobe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (lp_strobe),
        .load_en (load_en),
        .blank   (blank),
        .state_o (fsm_state)
    );

    seg_row_reg #(.W(SEG_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d       (row_data),
        .q       (row_q)
    );

    seg_mode_decode u_dec (
        .blank      (blank),
        .disp_on    (disp_on),
        .all_on     (all_on),
        .reverse_on (reverse_on),
        .mode       (mode)
    );

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        seg_slice_mux #(.W(SLICE_W)) u_mux (
            .mode (mode),
            .row  (row_q[s*SLICE_W +: SLICE_W]),
            .seg  (seg_out[s*SLICE_W +: SLICE_W])
        );
    end

endmodule

// File: rtl/seg_line_latch_chk.sv
module seg_line_latch_chk
    import seg_disp_pkg::*;
#(
    parameter int SEG_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lp_strobe,
    input logic [SEG_W-1:0] row_data,
    input logic             disp_on,
    input logic             all_on,
    input logic             reverse_on,
    input logic [SEG_W-1:0] seg_out,
    input logic [SEG_W-1:0] row_q,
    input stb_state_e       st
);

    // R1
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == STB_BLANK) |-> (seg_out == '0));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == STB_ARMED && lp_strobe) |=> (row_q == $past(row_data)));

    // R3
    held_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == STB_HELD) |=> $stable(row_q));

    // R4
    low_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_strobe) |=> $stable(row_q));

    // R5
    off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_on) |-> (seg_out == '0));

    // R6
    allon_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && all_on && st != STB_BLANK) |-> (seg_out == '1));

    // R7
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && !all_on && st != STB_BLANK)
            |-> ((seg_out ^ row_q) == {SEG_W{reverse_on}}));

endmodule

bind seg_line_latch seg_line_latch_chk #(.SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_strobe  (lp_strobe),
    .row_data   (row_data),
    .disp_on    (disp_on),
    .all_on     (all_on),
    .reverse_on (reverse_on),
    .seg_out    (seg_out),
    .row_q      (row_q),
    .st         (fsm_state)
);

// File: tb/tb_seg_line_latch.sv
module tb_seg_line_latch;

    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lp_strobe = 1'b1;
    logic [W-1:0] row_data = '0;
    logic         disp_on = 1'b1;
    logic         all_on = 1'b1;
    logic         reverse_on = 1'b0;
    logic [W-1:0] seg_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    // bench model of the requirements
    logic [W-1:0] m_row = '0;
    bit           m_seen = 0;
    bit           m_armed = 0;

    always #2 clk = ~clk;   // 250 MHz

    seg_line_latch dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_strobe  (lp_strobe),
        .row_data   (row_data),
        .disp_on    (disp_on),
        .all_on     (all_on),
        .reverse_on (reverse_on),
        .seg_out    (seg_out)
    );

    function automatic logic [W-1:0] exp_seg();
        if (!m_seen || !disp_on) return '0;   // R1, R5
        if (all_on)              return '1;   // R6
        if (reverse_on)          return ~m_row; // R7
        return m_row;
    endfunction

    function automatic logic [W-1:0] rnd_row();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input string tag);
        logic [W-1:0] e;
        e = exp_seg();
        n_chk++;
        if (seg_out !== e) begin
            n_bad++;
            $display("FAIL %s: seg_out=%h expected=%h", tag, seg_out, e);
        end
    endtask

    // one clock: model updates at the edge, check just after
    task automatic step(input string tag);
        @(posedge clk);
        if (rst_n) begin
            if (lp_strobe && m_armed) begin
                m_row   = row_data;
                m_armed = 0;
            end else if (!lp_strobe) begin
                m_armed = 1;
                m_seen  = 1;
            end
        end
        #1;
        chk(tag);
        @(negedge clk);
    endtask

    function automatic string mode_tag();
        if (!m_seen)   return "R1";
        if (!disp_on)  return "R5";
        if (all_on)    return "R6";
        return "R7";
    endfunction

    initial begin
        void'($urandom(32'h5eed_0c0d));
        // R1: reset with strobe high and all-on requested
        row_data = rnd_row();
        repeat (3) @(negedge clk);
        chk("R1");
        rst_n = 1'b1;
        step("R1");
        row_data = rnd_row();
        step("R1");
        // strobe drops: leaves blank, all-on shows
        lp_strobe = 1'b0;
        step("R6");
        // R2: capture a row in normal mode
        all_on = 1'b0;
        row_data = 128'hF0F0_0000_FFFF_1234_8000_0000_0000_0001;
        lp_strobe = 1'b1;
        step("R2");
        // R3: hold strobe high while data changes
        row_data = rnd_row();
        step("R3");
        row_data = rnd_row();
        step("R3");
        // R4: strobe low with changing data
        lp_strobe = 1'b0;
        row_data = rnd_row();
        step("R4");
        row_data = rnd_row();
        step("R4");
        // R8: mode changes between edges
        #0.5;
        reverse_on = 1'b1; #0.5; chk("R8");
        all_on = 1'b1;     #0.5; chk("R8");
        disp_on = 1'b0;    #0.5; chk("R8");
        // R9: back to normal shows original row
        disp_on = 1'b1; all_on = 1'b0; reverse_on = 1'b0; #0.2;
        chk("R9");
        @(negedge clk);
        // R5 has priority over all-on and reverse
        disp_on = 1'b0; all_on = 1'b1; reverse_on = 1'b1;
        step("R5");
        // random mix
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 4) == 0) lp_strobe = ~lp_strobe;
            row_data   = rnd_row();
            disp_on    = ($urandom % 8) != 0;
            all_on     = ($urandom % 6) == 0;
            reverse_on = $urandom % 2;
            step(mode_tag());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule